// File: doc/BRIEF.md
# Dedicated Register Bank with Banked Stack Pointer

This block keeps a processor's special-purpose registers: the exception table base, the subroutine link register, a system stack pointer, a user stack pointer and a status word. Instruction logic reaches each of them by a small index. It also reaches a general-register slot, R15, that is backed by one of the two stack pointers. A stack-select flag inside the status word picks which one.

Single-cycle strobes serve control flow. A call strobe captures the incoming program counter into the link register. A return strobe presents the link register as the next program counter. An exception-entry strobe forces the stack-select flag to system, so the handler's R15 is the system stack. The system stack pointer is also always shown on a dedicated output for saving and restoring state.

Top module: `dreg_bank_top`

## Requirements
- R1: While reset is high at a rising edge, the table base loads 0x000FFC00, the system stack pointer loads 0x00000000 and the status word loads 0, which makes the stack select 0. The link register and user stack pointer keep arbitrary values until first written.
- R2: While the stack select is 0, R15 reads return the system stack pointer and R15 writes update it at the next rising edge.
- R3: While the stack select is 1, R15 reads return the user stack pointer and R15 writes update it at the next rising edge.
- R4: Each dedicated register can be written and read back by its index: 0 table base, 1 link, 2 system stack, 3 user stack, 4 status. Indices 2 and 3 work whatever the stack select is.
- R5: A call strobe copies the program counter input into the link register at the rising edge.
- R6: While the return strobe is high, the next-PC valid output is 1 and the next-PC output equals the link register. Otherwise the valid output is 0.
- R7: The status word keeps only condition bits [3:0], the stack select at bit 5 and the level field [20:16]. All other bits read as 0.
- R8: The exception stack output always shows the system stack pointer. An exception-entry strobe clears the stack select at the rising edge.
- R9: When a call strobe and an indexed write to the link register fall in one cycle, the program counter value is stored.
- R10: When an R15 write and a call strobe fall in one cycle, both registers are updated.
- R11: R15 uses the stack select held at the start of the cycle. A status write that changes it redirects R15 only from the next cycle.
- R12: When an R15 write and an indexed write target the same stack pointer in one cycle, the R15 value is stored.
- R13: Indices 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dr_rd_idx | input | 3 | Index for the indexed read |
| dr_rd_data | output | 32 | Indexed read data (combinational) |
| dr_wr_en | input | 1 | Indexed write enable |
| dr_wr_idx | input | 3 | Index for the indexed write |
| dr_wr_data | input | 32 | Indexed write data |
| r15_rd_data | output | 32 | R15 read data, the selected stack pointer |
| r15_wr_en | input | 1 | R15 write enable |
| r15_wr_data | input | 32 | R15 write data |
| pc_in | input | 32 | Current program counter |
| call_stb | input | 1 | Subroutine call strobe |
| ret_stb | input | 1 | Subroutine return strobe |
| pc_next | output | 32 | Return target |
| pc_next_vld | output | 1 | Return target valid |
| exc_entry | input | 1 | Exception entry strobe |
| exc_sp | output | 32 | System stack pointer used for state save and restore |
| stk_sel | output | 1 | Current stack select flag |

## Verification
Several functions can land in one cycle. The cases are: a call strobe with an indexed link write, an R15 write with a call strobe, an R15 write with an indexed write to the same stack pointer, and a status write that flips the stack select while R15 is written. The bench drives each such pair in a single cycle. It then reads the affected registers back by index and compares them with the priority and sampling rules in R9 to R12.

// File: rtl/dreg_pkg.sv
package dreg_pkg;

    localparam int DW = 32;
    localparam int IW = 3;
    localparam int NUM_SP = 2;

    typedef enum logic [IW-1:0] {
        DRI_TBASE  = 3'd0,
        DRI_RETPTR = 3'd1,
        DRI_SSTK   = 3'd2,
        DRI_USTK   = 3'd3,
        DRI_STATUS = 3'd4
    } dreg_idx_e;

    typedef struct packed {
        logic [10:0] rsv_hi;
        logic [4:0]  ilvl;
        logic [9:0]  rsv_mid;
        logic        sflag;
        logic        rsv_lo;
        logic [3:0]  cond;
    } status_t;

    localparam logic [DW-1:0] STATUS_MASK = 32'h001F_002F;

    typedef struct packed {
        logic            en;
        dreg_idx_e       idx;
        logic [DW-1:0]   data;
    } wr_req_t;

    function automatic status_t status_clean(input logic [DW-1:0] raw);
        return status_t'(raw & STATUS_MASK);
    endfunction

    function automatic logic wr_hits(input wr_req_t req, input dreg_idx_e target);
        return req.en && (req.idx == target);
    endfunction

endpackage

// File: rtl/dreg_stack_bank.sv
module dreg_stack_bank
    import dreg_pkg::*;
#(
    parameter logic [DW-1:0] SSP_RST = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sflag,
    input  logic          r15_we,
    input  logic [DW-1:0] r15_wd,
    input  wr_req_t       wreq,
    output logic [DW-1:0] ssp_q,
    output logic [DW-1:0] usp_q,
    output logic [DW-1:0] r15_rd
);

    localparam logic [NUM_SP-1:0] BANK_HAS_RST = 2'b01;

    logic [DW-1:0] sp_q [NUM_SP];

    for (genvar b = 0; b < NUM_SP; b++) begin : g_bank
        localparam dreg_idx_e BANK_IDX = (b == 0) ? DRI_SSTK : DRI_USTK;
        logic          hit_r15;
        logic          hit_idx;
        logic [DW-1:0] nxt;

        always_comb begin
            hit_r15 = r15_we && (sflag == b[0]);
            hit_idx = wr_hits(wreq, BANK_IDX);
            nxt     = hit_r15 ? r15_wd : wreq.data;
        end

        if (BANK_HAS_RST[b]) begin : g_rst
            always_ff @(posedge clk) begin
                if (rst) begin
                    sp_q[b] <= SSP_RST;
                end else if (hit_r15 || hit_idx) begin
                    sp_q[b] <= nxt;
                end
            end
        end else begin : g_norst
            always_ff @(posedge clk) begin
                if (hit_r15 || hit_idx) begin
                    sp_q[b] <= nxt;
                end
            end
        end
    end

    always_comb begin
        ssp_q  = sp_q[0];
        usp_q  = sp_q[1];
        r15_rd = sflag ? sp_q[1] : sp_q[0];
    end

endmodule

// File: rtl/dreg_link_unit.sv
module dreg_link_unit
    import dreg_pkg::*;
#(
    parameter logic [DW-1:0] TBASE_RST = 32'h000F_FC00
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       wreq,
    input  logic          call_stb,
    input  logic          ret_stb,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] tbase_q,
    output logic [DW-1:0] rp_q,
    output logic [DW-1:0] pc_next,
    output logic          pc_next_vld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tbase_q <= TBASE_RST;
        end else if (wr_hits(wreq, DRI_TBASE)) begin
            tbase_q <= wreq.data;
        end
    end

    always_ff @(posedge clk) begin
        if (call_stb) begin
            rp_q <= pc_in;
        end else if (wr_hits(wreq, DRI_RETPTR)) begin
            rp_q <= wreq.data;
        end
    end

    always_comb begin
        pc_next_vld = ret_stb;
        pc_next     = ret_stb ? rp_q : '0;
    end

endmodule

// File: rtl/dreg_status_unit.sv
module dreg_status_unit
    import dreg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wreq,
    input  logic    exc_entry,
    output status_t status_q
);

    status_t status_nxt;

    always_comb begin
        status_nxt = status_q;
        if (wr_hits(wreq, DRI_STATUS)) begin
            status_nxt = status_clean(wreq.data);
        end
        if (exc_entry) begin
            status_nxt.sflag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= status_nxt;
        end
    end

endmodule

// File: rtl/dreg_bank_top.sv
module dreg_bank_top
    import dreg_pkg::*;
#(
    parameter logic [31:0] TBASE_RST = 32'h000F_FC00,
    parameter logic [31:0] SSP_RST   = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  dr_rd_idx,
    output logic [31:0] dr_rd_data,
    input  logic        dr_wr_en,
    input  logic [2:0]  dr_wr_idx,
    input  logic [31:0] dr_wr_data,
    output logic [31:0] r15_rd_data,
    input  logic        r15_wr_en,
    input  logic [31:0] r15_wr_data,
    input  logic [31:0] pc_in,
    input  logic        call_stb,
    input  logic        ret_stb,
    output logic [31:0] pc_next,
    output logic        pc_next_vld,
    input  logic        exc_entry,
    output logic [31:0] exc_sp,
    output logic        stk_sel
);

    wr_req_t       wreq;
    status_t       status_q;
    logic [DW-1:0] tbase_q;
    logic [DW-1:0] rp_q;
    logic [DW-1:0] ssp_q;
    logic [DW-1:0] usp_q;

    always_comb begin
        wreq.en   = dr_wr_en;
        wreq.idx  = dreg_idx_e'(dr_wr_idx);
        wreq.data = dr_wr_data;
    end

    dreg_status_unit u_status (
        .clk       (clk),
        .rst       (rst),
        .wreq      (wreq),
        .exc_entry (exc_entry),
        .status_q  (status_q)
    );

    dreg_link_unit #(
        .TBASE_RST (TBASE_RST)
    ) u_link (
        .clk         (clk),
        .rst         (rst),
        .wreq        (wreq),
        .call_stb    (call_stb),
        .ret_stb     (ret_stb),
        .pc_in       (pc_in),
        .tbase_q     (tbase_q),
        .rp_q        (rp_q),
        .pc_next     (pc_next),
        .pc_next_vld (pc_next_vld)
    );

    dreg_stack_bank #(
        .SSP_RST (SSP_RST)
    ) u_stack (
        .clk    (clk),
        .rst    (rst),
        .sflag  (status_q.sflag),
        .r15_we (r15_wr_en),
        .r15_wd (r15_wr_data),
        .wreq   (wreq),
        .ssp_q  (ssp_q),
        .usp_q  (usp_q),
        .r15_rd (r15_rd_data)
    );

    always_comb begin
        unique case (dreg_idx_e'(dr_rd_idx))
            DRI_TBASE:  dr_rd_data = tbase_q;
            DRI_RETPTR: dr_rd_data = rp_q;
            DRI_SSTK:   dr_rd_data = ssp_q;
            DRI_USTK:   dr_rd_data = usp_q;
            DRI_STATUS: dr_rd_data = status_q;
            default:    dr_rd_data = '0;
        endcase
        exc_sp  = ssp_q;
        stk_sel = status_q.sflag;
    end

endmodule

// File: rtl/dreg_bank_chk.sv
module dreg_bank_chk
    import dreg_pkg::*;
#(
    parameter logic [31:0] TBASE_RST = 32'h000F_FC00,
    parameter logic [31:0] SSP_RST   = 32'h0000_0000
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  dr_rd_idx,
    input logic [31:0] dr_rd_data,
    input logic        r15_wr_en,
    input logic [31:0] r15_wr_data,
    input logic [31:0] pc_in,
    input logic        call_stb,
    input logic        ret_stb,
    input logic [31:0] pc_next,
    input logic        pc_next_vld,
    input logic        exc_entry,
    input logic        stk_sel,
    input logic [31:0] tbase_q,
    input logic [31:0] rp_q,
    input logic [31:0] ssp_q,
    input logic [31:0] usp_q
);

    // R1
    reset_vals_chk: assert property (@(posedge clk)
        rst |=> (tbase_q == TBASE_RST && ssp_q == SSP_RST && !stk_sel));

    // R2
    r15_sys_chk: assert property (@(posedge clk) disable iff (rst)
        (r15_wr_en && !stk_sel) |=> (ssp_q == $past(r15_wr_data)));

    // R3
    r15_usr_chk: assert property (@(posedge clk) disable iff (rst)
        (r15_wr_en && stk_sel) |=> (usp_q == $past(r15_wr_data)));

    // R5
    call_link_chk: assert property (@(posedge clk) disable iff (rst)
        call_stb |=> (rp_q == $past(pc_in)));

    // R6
    ret_target_chk: assert property (@(posedge clk) disable iff (rst)
        ret_stb |-> (pc_next_vld && pc_next == rp_q));

    // R8
    exc_sel_chk: assert property (@(posedge clk) disable iff (rst)
        exc_entry |=> !stk_sel);

    // R7
    status_rsv_chk: assert property (@(posedge clk) disable iff (rst)
        (dr_rd_idx == 3'd4) |-> ((dr_rd_data & ~STATUS_MASK) == '0));

endmodule

bind dreg_bank_top dreg_bank_chk #(
    .TBASE_RST (TBASE_RST),
    .SSP_RST   (SSP_RST)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .dr_rd_idx   (dr_rd_idx),
    .dr_rd_data  (dr_rd_data),
    .r15_wr_en   (r15_wr_en),
    .r15_wr_data (r15_wr_data),
    .pc_in       (pc_in),
    .call_stb    (call_stb),
    .ret_stb     (ret_stb),
    .pc_next     (pc_next),
    .pc_next_vld (pc_next_vld),
    .exc_entry   (exc_entry),
    .stk_sel     (stk_sel),
    .tbase_q     (tbase_q),
    .rp_q        (rp_q),
    .ssp_q       (ssp_q),
    .usp_q       (usp_q)
);

// File: tb/dreg_bank_top_tb_top.sv
`timescale 1ns/100ps
module dreg_bank_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  dr_rd_idx = '0;
    logic [31:0] dr_rd_data;
    logic        dr_wr_en = 1'b0;
    logic [2:0]  dr_wr_idx = '0;
    logic [31:0] dr_wr_data = '0;
    logic [31:0] r15_rd_data;
    logic        r15_wr_en = 1'b0;
    logic [31:0] r15_wr_data = '0;
    logic [31:0] pc_in = '0;
    logic        call_stb = 1'b0;
    logic        ret_stb = 1'b0;
    logic [31:0] pc_next;
    logic        pc_next_vld;
    logic        exc_entry = 1'b0;
    logic [31:0] exc_sp;
    logic        stk_sel;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    dreg_bank_top dut_i (
        .clk(clk), .rst(rst),
        .dr_rd_idx(dr_rd_idx), .dr_rd_data(dr_rd_data),
        .dr_wr_en(dr_wr_en), .dr_wr_idx(dr_wr_idx), .dr_wr_data(dr_wr_data),
        .r15_rd_data(r15_rd_data), .r15_wr_en(r15_wr_en), .r15_wr_data(r15_wr_data),
        .pc_in(pc_in), .call_stb(call_stb), .ret_stb(ret_stb),
        .pc_next(pc_next), .pc_next_vld(pc_next_vld),
        .exc_entry(exc_entry), .exc_sp(exc_sp), .stk_sel(stk_sel)
    );

    // {index, write data, expected read-back}
    localparam logic [66:0] VEC [8] = '{
        {3'd0, 32'h0000_2000, 32'h0000_2000},
        {3'd1, 32'hCAFE_0010, 32'hCAFE_0010},
        {3'd2, 32'h0000_8000, 32'h0000_8000},
        {3'd3, 32'h0000_F000, 32'h0000_F000},
        {3'd4, 32'hFFFF_FFFF, 32'h001F_002F},
        {3'd4, 32'h0000_0000, 32'h0000_0000},
        {3'd7, 32'h1234_5678, 32'h0000_0000},
        {3'd0, 32'h000F_FC00, 32'h000F_FC00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [2:0] idx, input logic [31:0] exp);
        dr_rd_idx = idx;
        #0.1;
        chk(req, dr_rd_data, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        dr_wr_en = 1'b0; r15_wr_en = 1'b0; call_stb = 1'b0;
        ret_stb = 1'b0; exc_entry = 1'b0;
    endtask

    task automatic wr_idx(input logic [2:0] idx, input logic [31:0] d);
        dr_wr_en = 1'b1; dr_wr_idx = idx; dr_wr_data = d;
        tick();
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset values
        rd_chk("R1 tbase", 3'd0, 32'h000F_FC00);
        rd_chk("R1 ssp", 3'd2, 32'h0);
        rd_chk("R1 status", 3'd4, 32'h0);
        chk("R1 r15 is ssp", r15_rd_data, 32'h0);

        // table walk: R4 indexed access, R7 reserved bits, R13 unused index
        for (int i = 0; i < 8; i++) begin
            logic [2:0]  vi;
            logic [31:0] vd, ve;
            string tag;
            {vi, vd, ve} = VEC[i];
            tag = (vi == 3'd4) ? "R7" : ((vi > 3'd4) ? "R13" : "R4");
            wr_idx(vi, vd);
            rd_chk(tag, vi, ve);
        end
        rd_chk("R13 no side effect tbase", 3'd0, 32'h000F_FC00);
        rd_chk("R13 no side effect ssp", 3'd2, 32'h0000_8000);
        rd_chk("R13 no side effect usp", 3'd3, 32'h0000_F000);
        rd_chk("R13 idx5 zero", 3'd5, 32'h0);

        // R2 stack select 0
        r15_wr_en = 1'b1; r15_wr_data = 32'hA5A5_0001; tick();
        rd_chk("R2 ssp via r15", 3'd2, 32'hA5A5_0001);
        chk("R2 r15 read", r15_rd_data, 32'hA5A5_0001);
        rd_chk("R2 usp untouched", 3'd3, 32'h0000_F000);

        // R3 stack select 1 (status bit 5)
        wr_idx(3'd4, 32'h0000_0020);
        chk("R3 stk_sel", {31'b0, stk_sel}, 32'h1);
        chk("R3 r15 shows usp", r15_rd_data, 32'h0000_F000);
        r15_wr_en = 1'b1; r15_wr_data = 32'h5A5A_0002; tick();
        rd_chk("R3 usp via r15", 3'd3, 32'h5A5A_0002);
        rd_chk("R3 ssp untouched", 3'd2, 32'hA5A5_0001);

        // R4 explicit ssp write while select is 1
        wr_idx(3'd2, 32'h0000_1111);
        rd_chk("R4 ssp by index", 3'd2, 32'h0000_1111);
        chk("R4 r15 still usp", r15_rd_data, 32'h5A5A_0002);

        // R10 R15 write (usp) together with call
        r15_wr_en = 1'b1; r15_wr_data = 32'h0000_3333;
        call_stb = 1'b1; pc_in = 32'h0000_0C00; tick();
        rd_chk("R10 link", 3'd1, 32'h0000_0C00);
        rd_chk("R10 usp", 3'd3, 32'h0000_3333);

        // R8 exception entry
        exc_entry = 1'b1;
        #0.1 chk("R8 exc_sp is ssp", exc_sp, 32'h0000_1111);
        tick();
        chk("R8 select cleared", {31'b0, stk_sel}, 32'h0);
        chk("R8 r15 is ssp", r15_rd_data, 32'h0000_1111);

        // R11 status write flips select while R15 written
        dr_wr_en = 1'b1; dr_wr_idx = 3'd4; dr_wr_data = 32'h0000_0020;
        r15_wr_en = 1'b1; r15_wr_data = 32'h0000_2222; tick();
        rd_chk("R11 old select used ssp", 3'd2, 32'h0000_2222);
        rd_chk("R11 usp untouched", 3'd3, 32'h0000_3333);
        chk("R11 select now 1", {31'b0, stk_sel}, 32'h1);
        wr_idx(3'd4, 32'h0);

        // R12 R15 write beats indexed write to same stack pointer
        r15_wr_en = 1'b1; r15_wr_data = 32'h0000_4444;
        dr_wr_en = 1'b1; dr_wr_idx = 3'd2; dr_wr_data = 32'h0000_5555; tick();
        rd_chk("R12 r15 wins", 3'd2, 32'h0000_4444);

        // R5 call
        call_stb = 1'b1; pc_in = 32'h0000_0400; tick();
        rd_chk("R5 link", 3'd1, 32'h0000_0400);

        // R6 return
        chk("R6 idle vld", {31'b0, pc_next_vld}, 32'h0);
        ret_stb = 1'b1;
        #0.1;
        chk("R6 vld", {31'b0, pc_next_vld}, 32'h1);
        chk("R6 target", pc_next, 32'h0000_0400);
        tick();

        // R9 call beats indexed link write
        call_stb = 1'b1; pc_in = 32'h0000_0800;
        dr_wr_en = 1'b1; dr_wr_idx = 3'd1; dr_wr_data = 32'h0000_0999; tick();
        rd_chk("R9 call wins", 3'd1, 32'h0000_0800);

        // R1 reset again
        rst = 1'b1; tick(); rst = 1'b0;
        rd_chk("R1 tbase after reset", 3'd0, 32'h000F_FC00);
        rd_chk("R1 ssp after reset", 3'd2, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule